// File: doc/BRIEF.md
# Host Bus Style Auto-Detector

This block sits on the control side of an 8-bit microcontroller port. After a hardware reset it watches the host's first accesses and works out two facts without configuration pins. The first is the strobe style: either one read strobe and one write strobe, or one data strobe with a read/not-write direction line. The second is whether the bus multiplexes address and data, or carries a separate, live address bit 0. When the first read reaches the block, both answers are frozen until the next reset.

All pins are asynchronous to the core clock and pass through a synchroniser of `SYNC_STAGES` flops. The block drives two registered mode flags, a lock flag and decoded internal read and write strobes. These strobes present the host's accesses to the register logic in one uniform form, whatever strobe style the host uses. The host brings up the block with one write and then one read to an odd register address. The write selects the strobe style, the odd address selects the bus type, and the read locks both.

Top module: `host_bus_detect`

## Requirements
- R1: After reset release with idle pins (`cs_n`, `strb_a_n`, `strb_b_n` high; `a0`, `ale` low), `style_ds`, `bus_demux`, `modes_locked`, `int_rd` and `int_wr` are all 0. `style_ds`=0 means separate strobes and `bus_demux`=0 means multiplexed.
- R2: Before lock, a sampled cycle with `cs_n`, `strb_a_n` and `strb_b_n` all low sets `style_ds` to 1 (data strobe plus direction style).
- R3: Before lock, a sampled cycle with `cs_n` low, at least one of `strb_a_n`/`strb_b_n` low, `ale` low and `a0` high sets `bus_demux` to 1.
- R4: `a0` high while `ale` is high does not set `bus_demux`.
- R5: Control or address activity while `cs_n` is high changes no output.
- R6: A read cycle (`cs_n` low, `strb_a_n` low, `strb_b_n` high) sets `modes_locked`. Observations made in that same cycle still update the flags. After that, `style_ds` and `bus_demux` stay fixed until reset.
- R7: Asserting `rst_n` low clears the flags, the lock and both strobes.
- R8: `int_rd` is 1 exactly for read cycles as defined in R6, in both styles.
- R9: `int_wr` is 1 for `cs_n` low, `strb_b_n` low and `strb_a_n` high in separate style. In data strobe style it is 1 for `cs_n`, `strb_a_n` and `strb_b_n` all low. The style used is the one that includes the same cycle's update.
- R10: Every output reflects the pin values present `SYNC_STAGES`+1 rising clock edges earlier (3 edges at default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| strb_a_n | input | 1 | Read strobe (separate style) or data strobe (DS style), active low |
| strb_b_n | input | 1 | Write strobe (separate style) or read/not-write line (DS style) |
| a0 | input | 1 | Address bit 0 |
| ale | input | 1 | Address latch strobe, high while the address phase is on the bus |
| style_ds | output | 1 | 1: data strobe plus direction style |
| bus_demux | output | 1 | 1: non-multiplexed bus |
| modes_locked | output | 1 | Both mode flags frozen |
| int_rd | output | 1 | Decoded internal read strobe |
| int_wr | output | 1 | Decoded internal write strobe |

## Verification
Every result appears three rising edges after the pin pattern that causes it: two synchroniser edges and one output register edge. The mode flags, the lock and the decoded strobes all share that latency. The bench changes pins only on falling edges. Its reference model keeps a queue that delays each pin sample by two edges and updates on every rising edge. The model's outputs are compared with the design at the following falling edge. Explicit checks also wait out the delay, and one of them samples the edges just before and just at the third.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned PIN_W = 5;

  typedef struct packed {
    logic cs_n;
    logic a_n;
    logic b_n;
    logic a0;
    logic ale;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, a_n: 1'b1, b_n: 1'b1, a0: 1'b0, ale: 1'b0};
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int unsigned W       = 5,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hbd_mode_track.sv
module hbd_mode_track
  import hbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pins,
  output logic  style_nx,
  output logic  style_q,
  output logic  demux_q,
  output logic  locked_q
);
  logic cs_act, a_act, b_act;
  logic access, ds_seen, demux_seen, rd_seen;
  logic demux_nx, locked_nx, upd_en;

  always_comb begin
    cs_act     = ~pins.cs_n;
    a_act      = ~pins.a_n;
    b_act      = ~pins.b_n;
    access     = cs_act & (a_act | b_act);
    ds_seen    = cs_act & a_act & b_act;
    demux_seen = access & pins.a0 & ~pins.ale;
    rd_seen    = cs_act & a_act & ~b_act;
    upd_en     = ~locked_q;
    style_nx   = upd_en ? (style_q | ds_seen)    : style_q;
    demux_nx   = upd_en ? (demux_q | demux_seen) : demux_q;
    locked_nx  = locked_q | rd_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q  <= 1'b0;
      demux_q  <= 1'b0;
      locked_q <= 1'b0;
    end else if (upd_en) begin
      style_q  <= style_nx;
      demux_q  <= demux_nx;
      locked_q <= locked_nx;
    end
  end
endmodule

// File: rtl/hbd_strobe_dec.sv
module hbd_strobe_dec
  import hbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pins,
  input  logic  style_nx,
  output logic  rd_q,
  output logic  wr_q
);
  logic rd_nx, wr_nx, wr_sep, wr_ds;

  always_comb begin
    rd_nx  = ~pins.cs_n & ~pins.a_n &  pins.b_n;
    wr_sep = ~pins.cs_n &  pins.a_n & ~pins.b_n;
    wr_ds  = ~pins.cs_n & ~pins.a_n & ~pins.b_n;
    wr_nx  = style_nx ? wr_ds : wr_sep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_nx;
      wr_q <= wr_nx;
    end
  end
endmodule

// File: rtl/host_bus_detect.sv
module host_bus_detect
  import hbd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic strb_a_n,
  input  logic strb_b_n,
  input  logic a0,
  input  logic ale,
  output logic style_ds,
  output logic bus_demux,
  output logic modes_locked,
  output logic int_rd,
  output logic int_wr
);
  localparam logic [PIN_W-1:0] IDLE_VEC = PINS_IDLE;

  logic             core_rst_n;
  logic [PIN_W-1:0] raw_vec, sync_vec;
  pins_t            pins_s;
  logic             style_nx;

  assign raw_vec = {cs_n, strb_a_n, strb_b_n, a0, ale};
  assign pins_s  = pins_t'(sync_vec);

  hbd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(core_rst_n)
  );

  hbd_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VEC)) u_sync (
    .clk(clk), .rst_n(core_rst_n), .d(raw_vec), .q(sync_vec)
  );

  hbd_mode_track u_track (
    .clk(clk), .rst_n(core_rst_n), .pins(pins_s), .style_nx(style_nx),
    .style_q(style_ds), .demux_q(bus_demux), .locked_q(modes_locked)
  );

  hbd_strobe_dec u_dec (
    .clk(clk), .rst_n(core_rst_n), .pins(pins_s), .style_nx(style_nx),
    .rd_q(int_rd), .wr_q(int_wr)
  );
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic clk,
  input logic rst_n,
  input logic style_ds,
  input logic bus_demux,
  input logic modes_locked,
  input logic int_rd,
  input logic int_wr
);
  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modes_locked |=> modes_locked);
  // R6
  flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modes_locked |=> ($stable(style_ds) && $stable(bus_demux)));
  // R2
  style_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    style_ds |=> style_ds);
  // R3
  demux_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_demux |=> bus_demux);
  // R8
  read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |-> modes_locked);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rd && int_wr));
endmodule

bind host_bus_detect hbd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .style_ds(style_ds), .bus_demux(bus_demux),
  .modes_locked(modes_locked), .int_rd(int_rd), .int_wr(int_wr)
);

// File: tb/host_bus_detect_test.sv
module host_bus_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sa_n = 1'b1, sb_n = 1'b1, a0 = 1'b0, ale = 1'b0;
  logic style_ds, bus_demux, modes_locked, int_rd, int_wr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit saw_rd = 0, saw_wr = 0;

  always #5 clk = ~clk;

  host_bus_detect uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strb_a_n(sa_n), .strb_b_n(sb_n),
    .a0(a0), .ale(ale), .style_ds(style_ds), .bus_demux(bus_demux),
    .modes_locked(modes_locked), .int_rd(int_rd), .int_wr(int_wr)
  );

  // Behavioural reference: pins delayed two edges, then applied at the third.
  logic [4:0] pin_q[$];
  bit m_style, m_demux, m_lock, m_rd, m_wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q = {};
      pin_q.push_back(5'b11100);
      pin_q.push_back(5'b11100);
      {m_style, m_demux, m_lock, m_rd, m_wr} = '0;
    end else begin
      logic [4:0] p;
      bit sel, ra, rb;
      pin_q.push_back({cs_n, sa_n, sb_n, a0, ale});
      p = pin_q.pop_front();
      sel = !p[4]; ra = !p[3]; rb = !p[2];
      if (!m_lock) begin
        if (sel && ra && rb) m_style = 1;
        if (sel && (ra || rb) && p[1] && !p[0]) m_demux = 1;
        if (sel && ra && !rb) m_lock = 1;
      end
      m_rd = sel && ra && !rb;
      if (m_style) m_wr = sel && ra && rb;
      else         m_wr = sel && rb && !ra;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (int_rd) saw_rd = 1;
    if (int_wr) saw_wr = 1;
    if (rst_n && !done) begin
      chk("R2 style model", style_ds, m_style);
      chk("R3 demux model", bus_demux, m_demux);
      chk("R6 lock model", modes_locked, m_lock);
      chk("R8 int_rd model", int_rd, m_rd);
      chk("R9 int_wr model", int_wr, m_wr);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pins(input logic c, input logic a, input logic b,
                          input logic ad, input logic l);
    @(negedge clk);
    cs_n = c; sa_n = a; sb_n = b; a0 = ad; ale = l;
  endtask

  task automatic access(input logic c, input logic a, input logic b,
                        input logic ad, input logic l);
    set_pins(c, a, b, ad, l);
    idle(3);
    set_pins(1, 1, 1, 0, 0);
    idle(5);
    saw_rd = 0; saw_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cs_n = 1; sa_n = 1; sb_n = 1; a0 = 0; ale = 0;
    idle(3);
    rst_n = 1;
    idle(5);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 style", style_ds, 0);
    chk("R1 demux", bus_demux, 0);
    chk("R1 lock", modes_locked, 0);
    chk("R1 rd", int_rd, 0);
    chk("R1 wr", int_wr, 0);

    // R5: activity without chip select
    access(1, 0, 0, 1, 0);
    chk("R5 style", style_ds, 0);
    chk("R5 demux", bus_demux, 0);
    chk("R5 lock", modes_locked, 0);

    // R4: a0 high during address phase
    access(0, 1, 0, 1, 1);
    chk("R4 demux", bus_demux, 0);

    // Separate style: odd write then odd read (R3, R6, R9, R8)
    set_pins(0, 1, 0, 1, 0); idle(4);
    chk("R9 sep write strobe", saw_wr, 1);
    set_pins(1, 1, 1, 0, 0); idle(5);
    chk("R3 demux set", bus_demux, 1);
    chk("R2 style stays sep", style_ds, 0);
    // R10 latency of read
    set_pins(0, 0, 1, 1, 0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 before third edge", int_rd, 0);
    @(posedge clk); @(negedge clk);
    chk("R10 at third edge", int_rd, 1);
    chk("R8 read strobe", int_rd, 1);
    chk("R6 locked", modes_locked, 1);
    set_pins(1, 1, 1, 0, 0); idle(5);

    // R7 reset clears
    do_reset();
    chk("R7 style", style_ds, 0);
    chk("R7 demux", bus_demux, 0);
    chk("R7 lock", modes_locked, 0);

    // DS style: write even, read odd (R2, R9, R6 same-cycle demux)
    saw_wr = 0;
    set_pins(0, 0, 0, 0, 0); idle(4);
    chk("R9 ds write strobe", saw_wr, 1);
    set_pins(1, 1, 1, 0, 0); idle(5);
    chk("R2 style ds", style_ds, 1);
    chk("R2 demux still mux", bus_demux, 0);
    access(0, 0, 1, 1, 0);
    chk("R6 lock-cycle demux", bus_demux, 1);
    chk("R6 lock ds", modes_locked, 1);

    // R6 frozen after lock in separate style
    do_reset();
    access(0, 1, 0, 0, 0);
    access(0, 0, 1, 0, 0);
    chk("R6 lock sep", modes_locked, 1);
    access(0, 0, 0, 1, 0);
    chk("R6 style frozen", style_ds, 0);
    chk("R6 demux frozen", bus_demux, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule